// File: doc/BRIEF.md
# DDR Sleep-State Rail Sequencer

This block drives the rail controls of a DDR memory power domain. Two sleep-state inputs are synchronized and decoded into one of three states. In the fully active state the main, reference and termination rails are all enabled. In the light-sleep state the termination rail is switched to high impedance while the main and reference rails stay up. In the off state all three rails are dropped and their discharge paths are turned on. A supply-health flag with hysteresis gates the whole sequence.

When the main rail is brought up, a digital reference code ramps from zero to full scale at a fixed pace. This pace sets a soft-start window whose length does not depend on the switching rate. If the output still holds charge from before, the switch gates stay blocked until the ramp code reaches the sensed feedback code. This lets the output start from the level it already has. A startup-done flag marks the end of the ramp, and later protection features use it as their enable.

Top module: `ddr_rail_seq`

## Requirements
- R1: When both synchronized sleep inputs are high and power is good, `main_en`, `ref_en` and `term_en` are 1, `term_hiz` is 0, and all discharge outputs are 0.
- R2: When the light-sleep input (`s3_in`) is low, `s5_in` is high and power is good, `main_en` and `ref_en` are 1, `term_en` is 0 and `term_hiz` is 1.
- R3: When `s5_in` is low, for either value of `s3_in`, all enables and `term_hiz` are 0, and `main_dis`, `ref_dis` and `term_dis` are 1.
- R4: Each sleep input passes through two flip-flops. A change on an input shows at the rail outputs after the second rising clock edge and not after the first.
- R5: Power becomes good when `vcc_above_rise` is seen high while an enable input is high. Power is lost one edge after `vcc_below_fall` is seen high. While power is not good, every rail enable is 0.
- R6: While both synchronized enable inputs are low, the power-good state is dropped. Re-enabling with the supply inside the hysteresis band (both comparator inputs low) keeps the rails off until `vcc_above_rise` is seen again.
- R7: While the main rail is enabled, `ramp_code` starts at 0. It rises by STEP once every TICK_DIV clocks and saturates at 2^CODE_W-1. It never decreases while the rail stays on.
- R8: `gate_ok` stays 0 until the edge after the one at which `ramp_code >= fb_code` is sampled with the main rail on. After that it stays 1 until the rail turns off.
- R9: `start_done` rises one clock after `ramp_code` reaches full scale. It clears one edge after the main rail is disabled, whether by the off state or by loss of power.
- R10: A move between the fully active and light-sleep states does not restart the ramp and does not clear `start_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s3_in | input | 1 | Light-sleep control input, asynchronous |
| s5_in | input | 1 | Deep-sleep control input, asynchronous |
| vcc_above_rise | input | 1 | Bias supply above the rising threshold |
| vcc_below_fall | input | 1 | Bias supply below the falling threshold |
| fb_code | input | CODE_W | Digitized sensed output feedback |
| main_en | output | 1 | Main rail enable |
| ref_en | output | 1 | Reference rail enable |
| term_en | output | 1 | Termination rail enable |
| term_hiz | output | 1 | Termination rail high-impedance control |
| main_dis | output | 1 | Main rail discharge enable |
| ref_dis | output | 1 | Reference rail discharge enable |
| term_dis | output | 1 | Termination rail discharge enable |
| gate_ok | output | 1 | Switch gates may be driven |
| ramp_code | output | CODE_W | Soft-start reference code |
| start_done | output | 1 | Soft-start completed |

## Verification
The bench builds the block with CODE_W=4, STEP=4 and TICK_DIV=2. With these values the whole ramp takes eight clocks, and the last step saturates from 12 to 15 rather than landing on full scale exactly. A feedback code of 9 falls between two ramp steps, so the release of `gate_ok` on a pre-charged output is tested where the ramp jumps past the feedback value instead of matching it.

// File: rtl/ddr_rail_seq.sv
module ddr_rail_seq #(
  parameter int CODE_W   = 10,
  parameter int STEP     = 4,
  parameter int TICK_DIV = 469
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s3_in,
  input  logic              s5_in,
  input  logic              vcc_above_rise,
  input  logic              vcc_below_fall,
  input  logic [CODE_W-1:0] fb_code,
  output logic              main_en,
  output logic              ref_en,
  output logic              term_en,
  output logic              term_hiz,
  output logic              main_dis,
  output logic              ref_dis,
  output logic              term_dis,
  output logic              gate_ok,
  output logic [CODE_W-1:0] ramp_code,
  output logic              start_done
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

  logic [1:0] s3_q, s5_q;
  logic s3s, s5s, por_ok, rail_on, caught;
  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_q <= 2'b00;
      s5_q <= 2'b00;
    end else begin
      s3_q <= {s3_q[0], s3_in};
      s5_q <= {s5_q[0], s5_in};
    end
  end

  assign s3s = s3_q[1];
  assign s5s = s5_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      por_ok <= 1'b0;
    else if (!(s3s || s5s))
      por_ok <= 1'b0;
    else if (vcc_below_fall)
      por_ok <= 1'b0;
    else if (vcc_above_rise)
      por_ok <= 1'b1;
  end

  assign rail_on  = por_ok && s5s;
  assign main_en  = rail_on;
  assign ref_en   = rail_on;
  assign term_en  = rail_on && s3s;
  assign term_hiz = rail_on && !s3s;
  assign main_dis = !s5s;
  assign ref_dis  = !s5s;
  assign term_dis = !s5s;
  assign gate_ok  = rail_on && caught;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick       <= '0;
      ramp_code  <= '0;
      caught     <= 1'b0;
      start_done <= 1'b0;
    end else if (!rail_on) begin
      tick       <= '0;
      ramp_code  <= '0;
      caught     <= 1'b0;
      start_done <= 1'b0;
    end else begin
      if (ramp_code >= fb_code)
        caught <= 1'b1;
      start_done <= (ramp_code == FULL);
      if (ramp_code != FULL) begin
        if (tick == TICK_LAST) begin
          tick <= '0;
          if (ramp_code > FULL - STEP_C)
            ramp_code <= FULL;
          else
            ramp_code <= ramp_code + STEP_C;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  // R3
  discharge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_dis || term_dis) |-> !(main_en || term_en || term_hiz));

  // R7
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_en |=> (!main_en || ramp_code >= $past(ramp_code)));

  // R7
  ramp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> ramp_code == '0);

  // R8
  gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ok) |-> $past(ramp_code) >= $past(fb_code));

  // R9
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> ramp_code == FULL);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |=> !start_done);

  // R2
  term_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(term_en && term_hiz));
endmodule

// File: tb/tb_ddr_rail_seq.sv
module tb_ddr_rail_seq;
  localparam int CW = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s3_in = 1'b0, s5_in = 1'b0, vcc_above_rise = 1'b0, vcc_below_fall = 1'b0;
  logic [CW-1:0] fb_code = '0;
  logic main_en, ref_en, term_en, term_hiz, main_dis, ref_dis, term_dis, gate_ok, start_done;
  logic [CW-1:0] ramp_code;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ddr_rail_seq #(.CODE_W(CW), .STEP(4), .TICK_DIV(2)) dut (
    .clk(clk), .rst_n(rst_n), .s3_in(s3_in), .s5_in(s5_in),
    .vcc_above_rise(vcc_above_rise), .vcc_below_fall(vcc_below_fall),
    .fb_code(fb_code), .main_en(main_en), .ref_en(ref_en), .term_en(term_en),
    .term_hiz(term_hiz), .main_dis(main_dis), .ref_dis(ref_dis), .term_dis(term_dis),
    .gate_ok(gate_ok), .ramp_code(ramp_code), .start_done(start_done));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int rails();
    return {main_en, ref_en, term_en, term_hiz, main_dis, ref_dis, term_dis};
  endfunction

  task automatic t_reset();
    chk("R3 reset rails", rails(), 7'b0000111);
    chk("R7 reset ramp", ramp_code, 0);
    chk("R9 reset done", start_done, 0);
  endtask

  task automatic t_bringup();
    s3_in = 1; s5_in = 1; vcc_above_rise = 1; fb_code = 0;
    step(2);
    chk("R4 not after 2 edges", main_en, 0);
    step(1);
    chk("R1 S0 rails", rails(), 7'b1110000);
    chk("R7 ramp at start", ramp_code, 0);
    chk("R8 gate before catch", gate_ok, 0);
    step(1);
    chk("R8 gate after catch", gate_ok, 1);
    step(1);
    chk("R7 first step", ramp_code, 4);
    step(6);
    chk("R7 saturated", ramp_code, 15);
    chk("R9 done not yet", start_done, 0);
    step(1);
    chk("R9 done one later", start_done, 1);
  endtask

  task automatic t_sleep();
    s3_in = 0;
    step(1);
    chk("R4 sync 1 edge", term_en, 1);
    step(1);
    chk("R2 sleep rails", rails(), 7'b1101000);
    chk("R10 done kept", start_done, 1);
    chk("R10 ramp kept", ramp_code, 15);
    s3_in = 1;
    step(2);
    chk("R1 back to S0", rails(), 7'b1110000);
    chk("R10 done kept S0", start_done, 1);
  endtask

  task automatic t_off_odd();
    s3_in = 1; s5_in = 0;
    step(2);
    chk("R3 s3 high s5 low", rails(), 7'b0000111);
    step(1);
    chk("R9 done cleared off", start_done, 0);
    s3_in = 0;
    step(3);
    chk("R3 both low", rails(), 7'b0000111);
  endtask

  task automatic t_band();
    vcc_above_rise = 0; vcc_below_fall = 0;
    s3_in = 1; s5_in = 1;
    step(6);
    chk("R6 band keeps off", main_en, 0);
    chk("R6 no discharge", main_dis, 0);
    vcc_above_rise = 1;
    step(1);
    chk("R5 power good", main_en, 1);
  endtask

  task automatic t_por_loss();
    step(12);
    chk("R9 done before loss", start_done, 1);
    vcc_above_rise = 0; vcc_below_fall = 1;
    step(1);
    chk("R5 loss rails off", rails(), 7'b0000000);
    step(1);
    chk("R9 done cleared por", start_done, 0);
    vcc_below_fall = 0;
    step(3);
    chk("R5 stays off in band", main_en, 0);
  endtask

  task automatic t_prebias();
    vcc_above_rise = 0; s3_in = 0; s5_in = 0;
    step(4);
    fb_code = 9; s3_in = 1; s5_in = 1; vcc_above_rise = 1;
    step(3);
    chk("R1 on again", main_en, 1);
    step(6);
    chk("R7 ramp at 12", ramp_code, 12);
    chk("R8 gate held prebias", gate_ok, 0);
    step(1);
    chk("R8 gate released", gate_ok, 1);
    fb_code = 0;
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_bringup();
    t_sleep();
    t_off_odd();
    t_band();
    t_por_loss();
    t_prebias();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule